// File: doc/BRIEF.md
# Indirect Load Pointer-Update Unit

This block is the load-through-pointer slice of a small 8-bit microcontroller core. A sequencer hands it an already decoded instruction: the destination register, which 16-bit pointer pair to use, and how the pointer is adjusted. The block reads the pointer from its 32-entry byte register file and issues one read to a synchronous data memory. Depending on the adjustment code, it steps the pointer down before the access or up after it. It then writes the adjusted pointer back as two bytes and finally stores the fetched byte in the destination register.

The ordering of the final writes matters when the destination is itself one byte of the pointer being used. In that case the fetched byte is what remains in the register, not the adjusted pointer byte. Both writes land on the same clock edge, and the register file resolves the collision in favour of the destination write. A busy/done pair lets the sequencer stall while a load is in flight. A parameter selects between full-core timing, where every load takes two cycles, and reduced-core timing, where a load without pointer adjustment finishes in one cycle.

The register file also offers one plain write port and one combinational read port for the rest of the core.

Top module: `ldi_unit`

## Requirements
- R1: While reset is asserted and immediately after it, all 32 registers read as 0 and busy_o, done_o and mem_re_o are 0.
- R2: When start_i is high while the block is idle, mem_re_o is high in that same cycle. In that cycle mem_addr_o is the selected pointer minus one for mode code 2, and the unmodified pointer for every other code.
- R3: For mode code 1 the pointer pair is rewritten as pointer+1, and for mode code 2 as pointer-1. Bits 15:8 go to the higher-numbered register of the pair and bits 7:0 go to the lower one. Both bytes are written on the edge that ends the done cycle.
- R4: Mode codes 0 and 3 leave both pointer registers unchanged.
- R5: Pointer arithmetic wraps modulo 65536: pre-decrementing 0x0000 gives 0xFFFF, and post-incrementing 0xFFFF gives 0x0000.
- R6: The destination register receives the byte the memory returned for the load's address. When the destination is either byte of the pointer pair in use, that register ends up holding the memory byte, whatever the mode.
- R7: Pointer select code 2'b11 uses r27:r26, 2'b10 uses r29:r28, and both 2'b00 and 2'b01 use r31:r30 (high:low).
- R8: With start accepted in cycle C, done_o is a single-cycle pulse in cycle C+2. The one exception is reduced-core timing with mode code 0 or 3, where the pulse comes in cycle C+1. busy_o is high from C+1 up to and including the done cycle.
- R9: start_i is ignored while busy_o is high: mem_re_o stays low, and the load in progress completes with its own fields.
- R10: rd_data_o shows register rd_idx_i combinationally. An ext_we_i pulse while idle writes ext_data_i to register ext_idx_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a load (taken only when idle) |
| dst_i | input | 5 | Destination register index |
| ptr_sel_i | input | 2 | Pointer pair select (11 X, 10 Y, 00/01 Z) |
| mode_i | input | 2 | Adjust code: 0 none, 1 post-increment, 2 pre-decrement, 3 none |
| busy_o | output | 1 | A load is in flight |
| done_o | output | 1 | Final cycle of a load; register writes commit at its end |
| mem_re_o | output | 1 | Data-memory read strobe |
| mem_addr_o | output | 16 | Data-memory read address |
| mem_rdata_i | input | 8 | Data-memory read data, valid the cycle after mem_re_o |
| ext_we_i | input | 1 | General register write enable |
| ext_idx_i | input | 5 | General register write index |
| ext_data_i | input | 8 | General register write data |
| rd_idx_i | input | 5 | General register read index |
| rd_data_o | output | 8 | General register read data |

## Verification
The bench builds two copies side by side with the default 8-bit data and 32 registers: one with REDUCED_CORE=0 and one with REDUCED_CORE=1, both driven by the same stimulus. The reduced copy exercises the one-cycle path, in which the destination is committed straight from the memory's output. The full copy always goes through the holding register. Running them together shows on every load whether the latency difference appears only for the unadjusted modes, and whether both copies end up with identical register contents after pointer-half collisions and wrap-around.

// File: rtl/ldi_pkg.sv
package ldi_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_COMMIT = 2'd2
    } ldi_state_e;

    localparam logic [1:0] MODE_KEEP    = 2'd0;
    localparam logic [1:0] MODE_POSTINC = 2'd1;
    localparam logic [1:0] MODE_PREDEC  = 2'd2;

    localparam logic [1:0] SEL_X = 2'b11;
    localparam logic [1:0] SEL_Y = 2'b10;

endpackage

// File: rtl/ldi_ptr_math.sv
module ldi_ptr_math
    import ldi_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic [PTR_W-1:0] ptr_i,
    input  logic [1:0]       mode_i,
    output logic [PTR_W-1:0] addr_o,
    output logic [PTR_W-1:0] next_o,
    output logic             wb_o
);

    always_comb begin
        addr_o = ptr_i;
        next_o = ptr_i;
        wb_o   = 1'b0;
        unique case (mode_i)
            MODE_POSTINC: begin
                next_o = ptr_i + PTR_W'(1);
                wb_o   = 1'b1;
            end
            MODE_PREDEC: begin
                addr_o = ptr_i - PTR_W'(1);
                next_o = ptr_i - PTR_W'(1);
                wb_o   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ldi_regfile.sv
module ldi_regfile #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 32,
    localparam int REG_AW  = $clog2(NUM_REGS),
    localparam int PTR_W   = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_we_i,
    input  logic [REG_AW-1:0] ext_idx_i,
    input  logic [DATA_W-1:0] ext_data_i,
    input  logic              ptr_we_i,
    input  logic [REG_AW-1:0] ptr_hi_idx_i,
    input  logic [REG_AW-1:0] ptr_lo_idx_i,
    input  logic [DATA_W-1:0] ptr_hi_data_i,
    input  logic [DATA_W-1:0] ptr_lo_data_i,
    input  logic              dst_we_i,
    input  logic [REG_AW-1:0] dst_idx_i,
    input  logic [DATA_W-1:0] dst_data_i,
    input  logic [REG_AW-1:0] pair_idx_i,
    output logic [PTR_W-1:0]  pair_data_o,
    input  logic [REG_AW-1:0] rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] regs_q [NUM_REGS];
    logic [DATA_W-1:0] regs_d [NUM_REGS];

    // Later assignments win: general port, then pointer bytes, then destination.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (ext_we_i) begin
            regs_d[ext_idx_i] = ext_data_i;
        end
        if (ptr_we_i) begin
            regs_d[ptr_hi_idx_i] = ptr_hi_data_i;
            regs_d[ptr_lo_idx_i] = ptr_lo_data_i;
        end
        if (dst_we_i) begin
            regs_d[dst_idx_i] = dst_data_i;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_REGS; i++) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign pair_data_o = {regs_q[REG_AW'(pair_idx_i + 1'b1)], regs_q[pair_idx_i]};
    assign rd_data_o   = regs_q[rd_idx_i];

    AST_DST_BEATS_PTR_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we_i && ptr_we_i && dst_idx_i == ptr_hi_idx_i)
        |=> regs_q[$past(dst_idx_i)] == $past(dst_data_i)); // R6

    AST_DST_BEATS_PTR_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we_i && ptr_we_i && dst_idx_i == ptr_lo_idx_i)
        |=> regs_q[$past(dst_idx_i)] == $past(dst_data_i)); // R6

    AST_PTR_LO_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_we_i && !(dst_we_i && dst_idx_i == ptr_lo_idx_i))
        |=> regs_q[$past(ptr_lo_idx_i)] == $past(ptr_lo_data_i)); // R3

endmodule

// File: rtl/ldi_ctrl.sv
module ldi_ctrl
    import ldi_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int REG_AW       = 5,
    parameter bit REDUCED_CORE = 1'b0,
    localparam int PTR_W       = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REG_AW-1:0] dst_i,
    input  logic [REG_AW-1:0] base_i,
    input  logic              wb_i,
    input  logic [PTR_W-1:0]  next_ptr_i,
    input  logic [PTR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_re_o,
    output logic [PTR_W-1:0]  mem_addr_o,
    output logic              ptr_we_o,
    output logic [REG_AW-1:0] ptr_hi_idx_o,
    output logic [REG_AW-1:0] ptr_lo_idx_o,
    output logic [DATA_W-1:0] ptr_hi_data_o,
    output logic [DATA_W-1:0] ptr_lo_data_o,
    output logic              dst_we_o,
    output logic [REG_AW-1:0] dst_idx_o,
    output logic [DATA_W-1:0] dst_data_o
);

    typedef struct packed {
        ldi_state_e        st;
        logic              wb;
        logic              held;
        logic [PTR_W-1:0]  nptr;
        logic [REG_AW-1:0] dst;
        logic [REG_AW-1:0] base;
        logic [DATA_W-1:0] data;
    } ctl_t;

    ctl_t ctl_q;
    ctl_t ctl_d;
    logic accept_d;

    always_comb begin
        ctl_d    = ctl_q;
        accept_d = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    accept_d   = 1'b1;
                    ctl_d.wb   = wb_i;
                    ctl_d.held = 1'b0;
                    ctl_d.nptr = next_ptr_i;
                    ctl_d.dst  = dst_i;
                    ctl_d.base = base_i;
                    ctl_d.st   = (!REDUCED_CORE || wb_i) ? ST_HOLD : ST_COMMIT;
                end
            end
            ST_HOLD: begin
                ctl_d.data = mem_rdata_i;
                ctl_d.held = 1'b1;
                ctl_d.st   = ST_COMMIT;
            end
            ST_COMMIT: begin
                ctl_d.st = ST_IDLE;
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_o        = (ctl_q.st != ST_IDLE);
    assign done_o        = (ctl_q.st == ST_COMMIT);
    assign mem_re_o      = accept_d;
    assign mem_addr_o    = addr_i;
    assign ptr_we_o      = done_o && ctl_q.wb;
    assign ptr_lo_idx_o  = ctl_q.base;
    assign ptr_hi_idx_o  = REG_AW'(ctl_q.base + 1'b1);
    assign ptr_hi_data_o = ctl_q.nptr[PTR_W-1:DATA_W];
    assign ptr_lo_data_o = ctl_q.nptr[DATA_W-1:0];
    assign dst_we_o      = done_o;
    assign dst_idx_o     = ctl_q.dst;
    assign dst_data_o    = ctl_q.held ? ctl_q.data : mem_rdata_i;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8

    AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R8

    AST_NO_READ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !mem_re_o); // R9

    AST_PTR_WB_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we_o |-> (done_o && dst_we_o)); // R3

endmodule

// File: rtl/ldi_unit.sv
module ldi_unit
    import ldi_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int NUM_REGS     = 32,
    parameter bit REDUCED_CORE = 1'b0,
    localparam int REG_AW      = $clog2(NUM_REGS),
    localparam int PTR_W       = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [REG_AW-1:0] dst_i,
    input  logic [1:0]        ptr_sel_i,
    input  logic [1:0]        mode_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_re_o,
    output logic [PTR_W-1:0]  mem_addr_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              ext_we_i,
    input  logic [REG_AW-1:0] ext_idx_i,
    input  logic [DATA_W-1:0] ext_data_i,
    input  logic [REG_AW-1:0] rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int Z_LO = NUM_REGS - 2;
    localparam int Y_LO = NUM_REGS - 4;
    localparam int X_LO = NUM_REGS - 6;

    logic [REG_AW-1:0] base_idx;
    logic [PTR_W-1:0]  pair_data;
    logic [PTR_W-1:0]  eff_addr;
    logic [PTR_W-1:0]  next_ptr;
    logic              need_wb;

    logic              ptr_we;
    logic [REG_AW-1:0] ptr_hi_idx;
    logic [REG_AW-1:0] ptr_lo_idx;
    logic [DATA_W-1:0] ptr_hi_data;
    logic [DATA_W-1:0] ptr_lo_data;
    logic              dst_we;
    logic [REG_AW-1:0] dst_idx;
    logic [DATA_W-1:0] dst_data;

    always_comb begin
        unique case (ptr_sel_i)
            SEL_X:   base_idx = REG_AW'(X_LO);
            SEL_Y:   base_idx = REG_AW'(Y_LO);
            default: base_idx = REG_AW'(Z_LO);
        endcase
    end

    ldi_regfile #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) i_regfile (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_we_i      (ext_we_i),
        .ext_idx_i     (ext_idx_i),
        .ext_data_i    (ext_data_i),
        .ptr_we_i      (ptr_we),
        .ptr_hi_idx_i  (ptr_hi_idx),
        .ptr_lo_idx_i  (ptr_lo_idx),
        .ptr_hi_data_i (ptr_hi_data),
        .ptr_lo_data_i (ptr_lo_data),
        .dst_we_i      (dst_we),
        .dst_idx_i     (dst_idx),
        .dst_data_i    (dst_data),
        .pair_idx_i    (base_idx),
        .pair_data_o   (pair_data),
        .rd_idx_i      (rd_idx_i),
        .rd_data_o     (rd_data_o)
    );

    ldi_ptr_math #(
        .PTR_W (PTR_W)
    ) i_ptr_math (
        .ptr_i  (pair_data),
        .mode_i (mode_i),
        .addr_o (eff_addr),
        .next_o (next_ptr),
        .wb_o   (need_wb)
    );

    ldi_ctrl #(
        .DATA_W       (DATA_W),
        .REG_AW       (REG_AW),
        .REDUCED_CORE (REDUCED_CORE)
    ) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .dst_i         (dst_i),
        .base_i        (base_idx),
        .wb_i          (need_wb),
        .next_ptr_i    (next_ptr),
        .addr_i        (eff_addr),
        .mem_rdata_i   (mem_rdata_i),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .mem_re_o      (mem_re_o),
        .mem_addr_o    (mem_addr_o),
        .ptr_we_o      (ptr_we),
        .ptr_hi_idx_o  (ptr_hi_idx),
        .ptr_lo_idx_o  (ptr_lo_idx),
        .ptr_hi_data_o (ptr_hi_data),
        .ptr_lo_data_o (ptr_lo_data),
        .dst_we_o      (dst_we),
        .dst_idx_o     (dst_idx),
        .dst_data_o    (dst_data)
    );

endmodule

// File: tb/test_ldi_unit.sv
`timescale 1ns/1ps
module test_ldi_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  dst = '0;
    logic [1:0]  sel = '0;
    logic [1:0]  mode = '0;
    logic        ext_we = 1'b0;
    logic [4:0]  ext_idx = '0;
    logic [7:0]  ext_data = '0;
    logic [4:0]  rd_idx = '0;

    logic        busy_f, done_f, mre_f, busy_r, done_r, mre_r;
    logic [15:0] maddr_f, maddr_r;
    logic [7:0]  mrd_f = '0;
    logic [7:0]  mrd_r = '0;
    logic [7:0]  rdd_f, rdd_r;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    logic [7:0]  mdl [32];

    always #4 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
    endfunction

    always @(posedge clk) begin
        if (mre_f) mrd_f <= memf(maddr_f);
        if (mre_r) mrd_r <= memf(maddr_r);
    end

    ldi_unit #(.REDUCED_CORE(1'b0)) i_ldi_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dst_i(dst), .ptr_sel_i(sel),
        .mode_i(mode), .busy_o(busy_f), .done_o(done_f), .mem_re_o(mre_f),
        .mem_addr_o(maddr_f), .mem_rdata_i(mrd_f), .ext_we_i(ext_we),
        .ext_idx_i(ext_idx), .ext_data_i(ext_data), .rd_idx_i(rd_idx), .rd_data_o(rdd_f)
    );

    ldi_unit #(.REDUCED_CORE(1'b1)) i_ldi_unit_red (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dst_i(dst), .ptr_sel_i(sel),
        .mode_i(mode), .busy_o(busy_r), .done_o(done_r), .mem_re_o(mre_r),
        .mem_addr_o(maddr_r), .mem_rdata_i(mrd_r), .ext_we_i(ext_we),
        .ext_idx_i(ext_idx), .ext_data_i(ext_data), .rd_idx_i(rd_idx), .rd_data_o(rdd_r)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_reg(input string req, input int idx);
        rd_idx = 5'(idx);
        #1;
        chk(req, $sformatf("full r%0d", idx), int'(rdd_f), int'(mdl[idx]));
        chk(req, $sformatf("reduced r%0d", idx), int'(rdd_r), int'(mdl[idx]));
    endtask

    task automatic wr_reg(input int idx, input logic [7:0] v);
        @(negedge clk);
        ext_we = 1'b1; ext_idx = 5'(idx); ext_data = v;
        @(negedge clk);
        ext_we = 1'b0;
        mdl[idx] = v;
        chk_reg("R10", idx);
    endtask

    task automatic set_ptr(input int lo, input logic [15:0] v);
        wr_reg(lo, v[7:0]);
        wr_reg(lo + 1, v[15:8]);
    endtask

    task automatic do_load(input string req, input int d, input logic [1:0] s, input logic [1:0] m);
        int          base;
        int          lr;
        logic [15:0] ptr, addr, newp;
        logic [7:0]  data;
        base = (s == 2'b11) ? 26 : (s == 2'b10) ? 28 : 30;  // R7
        ptr  = {mdl[base + 1], mdl[base]};
        addr = (m == 2'd2) ? ptr - 16'd1 : ptr;              // R2
        newp = (m == 2'd1) ? ptr + 16'd1 : (m == 2'd2) ? ptr - 16'd1 : ptr;
        data = memf(addr);
        lr   = (m == 2'd1 || m == 2'd2) ? 2 : 1;             // R8
        @(negedge clk);
        start = 1'b1; dst = 5'(d); sel = s; mode = m;
        #1;
        chk("R2", "full mem_re", int'(mre_f), 1);
        chk("R2", "full mem_addr", int'(maddr_f), int'(addr));
        chk("R2", "reduced mem_re", int'(mre_r), 1);
        chk("R2", "reduced mem_addr", int'(maddr_r), int'(addr));
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk("R8", $sformatf("full busy k=%0d", k), int'(busy_f), int'(k <= 2));
            chk("R8", $sformatf("full done k=%0d", k), int'(done_f), int'(k == 2));
            chk("R8", $sformatf("reduced busy k=%0d", k), int'(busy_r), int'(k <= lr));
            chk("R8", $sformatf("reduced done k=%0d", k), int'(done_r), int'(k == lr));
            if (k == 1) begin
                chk("R9", "full mem_re while busy", int'(mre_f), 0);
                chk("R9", "reduced mem_re while busy", int'(mre_r), 0);
                dst = ~dst; sel = ~sel; mode = ~mode;   // junk request, must be ignored
            end else begin
                start = 1'b0;
            end
        end
        if (m == 2'd1 || m == 2'd2) begin
            mdl[base + 1] = newp[15:8];                     // R3
            mdl[base]     = newp[7:0];
        end
        mdl[d] = data;                                      // R6: loaded byte last
        chk_reg(req, base);
        chk_reg(req, base + 1);
        chk_reg("R6", d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1", "full busy in reset", int'(busy_f), 0);
        chk("R1", "full done in reset", int'(done_f), 0);
        chk("R1", "reduced mem_re in reset", int'(mre_r), 0);
        for (int i = 0; i < 32; i++) chk_reg("R1", i);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "full busy after reset", int'(busy_f), 0);
        chk("R1", "reduced done after reset", int'(done_r), 0);

        for (int i = 0; i < 8; i++) wr_reg(i, 8'(8'h11 * i + 3));
        set_ptr(26, 16'h1234);
        set_ptr(28, 16'h00FF);
        set_ptr(30, 16'h8000);

        do_load("R4", 1, 2'b11, 2'd0);   // X, no adjust
        do_load("R3", 2, 2'b10, 2'd1);   // Y, post-increment across byte carry
        do_load("R3", 3, 2'b00, 2'd2);   // Z, pre-decrement across byte borrow
        set_ptr(30, 16'h0000);
        do_load("R5", 4, 2'b00, 2'd2);   // Z wraps to 0xFFFF
        set_ptr(28, 16'hFFFF);
        do_load("R5", 5, 2'b10, 2'd1);   // Y wraps to 0x0000
        do_load("R6", 27, 2'b11, 2'd1);  // destination is X high byte
        do_load("R6", 30, 2'b00, 2'd2);  // destination is Z low byte
        do_load("R6", 26, 2'b11, 2'd0);  // destination is X low byte, no adjust
        do_load("R4", 6, 2'b10, 2'd3);   // code 3 behaves as no adjust
        do_load("R7", 7, 2'b01, 2'd1);   // select 01 uses Z

        for (int i = 0; i < 32; i++) chk_reg("R6", i);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule